// File: doc/BRIEF.md
# Paired-Page TLB Address Translator

The block turns a 32-bit virtual address into a 32-bit physical address for one load, store or instruction-fetch request at a time. Each request carries the address, the access size in bytes, a write flag, an 8-bit address-space identifier (ASID) and a kernel-mode flag. Addresses in the two unmapped kernel windows skip translation and map straight onto the low 512 MB of physical memory. Every other address goes to a small, fully associative, register-based array of entries. Each entry covers an even/odd pair of pages of a programmable size.

The result of a request is either a physical address or a fault code. A fault also reports the virtual page number, the ASID, the address and the write flag. Software loads the entries through a one-cycle write port. Requests and responses use valid/ready handshakes. Each accepted request has its response registered one cycle later.

Top module: `tlbx_translator`

## Requirements
- R1: A request accepted on a rising edge (req_valid_i and req_ready_o both high) produces rsp_valid_o high after that edge. While rsp_valid_o is high and rsp_ready_i is low, every response output holds its value. req_ready_o is high exactly when rsp_valid_o is low or rsp_ready_i is high.
- R2: An address with bits 31:29 = 3'b100 bypasses the array and gives physical address vaddr & 0x1FFFFFFF with fault code 0 (none). If req_kernel_i is low, or the access is misaligned, it gives fault code 1 (address error) instead.
- R3: An address with bits 31:29 = 3'b101 bypasses the array and gives vaddr & 0x1FFFFFFF with fault code 0. This holds regardless of mode or alignment.
- R4: Outside both bypass windows, an access with (vaddr[2:0] & (size-1)) nonzero gives fault code 1. rsp_write_o reports the request's write flag.
- R5: An entry matches when its stored VPN2 equals the request VPN on every bit above bit (1 + 2·psel), and either its global bit is set or its ASID equals the request ASID. When several entries match, the lowest index is used.
- R6: The request VPN is vaddr[31:11] with its two low bits cleared, unless small_pg_i is high, in which case they are kept. With no matching entry the fault code is 2 (refill). rsp_vpn_o, rsp_asid_o and rsp_write_o then report the request's VPN, ASID and write flag.
- R7: An entry's page shift is S = 12 + 2·psel. On a hit, vaddr[S] = 0 selects the even half (pfn0/v0/d0) and vaddr[S] = 1 selects the odd half (pfn1/v1/d1).
- R8: A hit whose selected valid bit is 0 gives fault code 3 (invalid) and reports the VPN.
- R9: A write that hits a valid half with dirty bit 0 gives fault code 4 (modified). A read of the same half succeeds.
- R10: On a successful hit, the physical address is ({pfn, 12'b0} with bits S-1:0 cleared) OR (vaddr bits S-1:0). rsp_paddr_o is 0 whenever the fault code is nonzero in the mapped region.
- R11: After reset, rsp_valid_o is 0 and every entry field is 0. A lookup of VPN 0 with ASID 0 therefore hits an invalid half and gives fault code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| small_pg_i | input | 1 | Keep the low two VPN bits |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_vaddr_i | input | 32 | Virtual address |
| req_size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| req_write_i | input | 1 | Store when high |
| req_asid_i | input | 8 | Address-space identifier |
| req_kernel_i | input | 1 | Kernel mode |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 3 | Entry index |
| wr_vpn2_i | input | 21 | Entry VPN2 |
| wr_asid_i | input | 8 | Entry ASID |
| wr_global_i | input | 1 | Entry matches any ASID |
| wr_psel_i | input | 2 | Page size select, S = 12 + 2·psel |
| wr_pfn0_i | input | 20 | Even page frame number |
| wr_v0_i | input | 1 | Even half valid |
| wr_d0_i | input | 1 | Even half dirty (writable) |
| wr_pfn1_i | input | 20 | Odd page frame number |
| wr_v1_i | input | 1 | Odd half valid |
| wr_d1_i | input | 1 | Odd half dirty (writable) |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_fault_o | output | 3 | 0 none, 1 address error, 2 refill, 3 invalid, 4 modified |
| rsp_vpn_o | output | 21 | Request VPN |
| rsp_vaddr_o | output | 32 | Request virtual address |
| rsp_asid_o | output | 8 | Request ASID |
| rsp_write_o | output | 1 | Request write flag |

## Verification
Translation is tried in several ways.
- Reads and writes to both halves of a 4 KB entry separate the even/odd selection from the dirty check.
- A 16 KB global entry with a nonzero low PFN field shows whether the page mask widens both the VPN compare and the offset merge.
- Two entries covering the same page show whether the lowest index wins.
- Wrong-ASID, out-of-array and small-page misses show how the VPN is reported.
- Bypass accesses in user mode and misaligned accesses in all regions separate the privilege and alignment rules of the two windows.
- A held-off response shows that the result stays put under backpressure.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int VA_W   = 32;
  localparam int VPN_W  = 21;
  localparam int PFN_W  = 20;
  localparam int ASID_W = 8;
  localparam int PSEL_W = 2;
  localparam int SZ_W   = 3;

  localparam logic [2:0] FLT_NONE     = 3'd0;
  localparam logic [2:0] FLT_ADDR     = 3'd1;
  localparam logic [2:0] FLT_REFILL   = 3'd2;
  localparam logic [2:0] FLT_INVALID  = 3'd3;
  localparam logic [2:0] FLT_MODIFIED = 3'd4;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn2;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PSEL_W-1:0] psel;
    logic [PFN_W-1:0]  pfn0;
    logic              v0;
    logic              d0;
    logic [PFN_W-1:0]  pfn1;
    logic              v1;
    logic              d1;
  } tlb_entry_t;
endpackage

// File: rtl/tlbx_entry_store.sv
module tlbx_entry_store
  import tlbx_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  tlb_entry_t        wr_entry_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              hit_o,
  output tlb_entry_t        hit_entry_o
);
  tlb_entry_t ent_q [N_ENT];
  logic [N_ENT-1:0] match;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic [VPN_W-1:0] cmp_mask;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ent_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))      ent_q[g] <= wr_entry_i;
    end

    // ignore VPN bits covered by the page pair
    assign cmp_mask = ~((VPN_W'(1) << (2 * int'(ent_q[g].psel) + 2)) - VPN_W'(1));
    assign match[g] = (((ent_q[g].vpn2 ^ lk_vpn_i) & cmp_mask) == '0) &&
                      (ent_q[g].glob || ent_q[g].asid == lk_asid_i);
  end

  always_comb begin
    hit_entry_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (match[i]) hit_entry_o = ent_q[i];
  end

  assign hit_o = |match;
endmodule

// File: rtl/tlbx_page_sel.sv
module tlbx_page_sel
  import tlbx_pkg::*;
(
  input  tlb_entry_t       entry_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             write_i,
  output logic [2:0]       fault_o,
  output logic [VA_W-1:0]  paddr_o
);
  logic [4:0]      shamt;
  logic            odd;
  logic [VA_W-1:0] off_mask;
  logic [PFN_W-1:0] pfn;
  logic            vld, dty;

  assign shamt    = 5'd12 + {2'b00, entry_i.psel, 1'b0};
  assign odd      = vaddr_i[shamt];
  assign off_mask = (VA_W'(1) << shamt) - VA_W'(1);
  assign pfn      = odd ? entry_i.pfn1 : entry_i.pfn0;
  assign vld      = odd ? entry_i.v1   : entry_i.v0;
  assign dty      = odd ? entry_i.d1   : entry_i.d0;

  always_comb begin
    paddr_o = '0;
    if (!vld)                fault_o = FLT_INVALID;
    else if (write_i && !dty) fault_o = FLT_MODIFIED;
    else begin
      fault_o = FLT_NONE;
      paddr_o = ({pfn, 12'h000} & ~off_mask) | (vaddr_i & off_mask);
    end
  end
endmodule

// File: rtl/tlbx_translator.sv
module tlbx_translator
  import tlbx_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              small_pg_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [31:0]       req_vaddr_i,
  input  logic [2:0]        req_size_i,
  input  logic              req_write_i,
  input  logic [7:0]        req_asid_i,
  input  logic              req_kernel_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [20:0]       wr_vpn2_i,
  input  logic [7:0]        wr_asid_i,
  input  logic              wr_global_i,
  input  logic [1:0]        wr_psel_i,
  input  logic [19:0]       wr_pfn0_i,
  input  logic              wr_v0_i,
  input  logic              wr_d0_i,
  input  logic [19:0]       wr_pfn1_i,
  input  logic              wr_v1_i,
  input  logic              wr_d1_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [31:0]       rsp_paddr_o,
  output logic [2:0]        rsp_fault_o,
  output logic [20:0]       rsp_vpn_o,
  output logic [31:0]       rsp_vaddr_o,
  output logic [7:0]        rsp_asid_o,
  output logic              rsp_write_o
);
  localparam logic [VA_W-1:0] UNMAP_MASK = 32'h1FFF_FFFF;

  tlb_entry_t       wr_entry, hit_entry;
  logic             hit, mis, seg_c, seg_u, accept;
  logic [VPN_W-1:0] vpn;
  logic [2:0]       pg_fault, fault_d;
  logic [VA_W-1:0]  pg_paddr, paddr_d;

  assign wr_entry = '{vpn2: wr_vpn2_i, asid: wr_asid_i, glob: wr_global_i,
                      psel: wr_psel_i, pfn0: wr_pfn0_i, v0: wr_v0_i, d0: wr_d0_i,
                      pfn1: wr_pfn1_i, v1: wr_v1_i, d1: wr_d1_i};

  assign mis   = |(req_vaddr_i[2:0] & (req_size_i - SZ_W'(1)));
  assign seg_c = req_vaddr_i[31:29] == 3'b100;
  assign seg_u = req_vaddr_i[31:29] == 3'b101;
  assign vpn   = small_pg_i ? req_vaddr_i[31:11] : {req_vaddr_i[31:13], 2'b00};

  tlbx_entry_store #(.N_ENT(N_ENT)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_idx_i, .wr_entry_i(wr_entry),
    .lk_vpn_i(vpn), .lk_asid_i(req_asid_i),
    .hit_o(hit), .hit_entry_o(hit_entry)
  );

  tlbx_page_sel u_sel (
    .entry_i(hit_entry), .vaddr_i(req_vaddr_i), .write_i(req_write_i),
    .fault_o(pg_fault), .paddr_o(pg_paddr)
  );

  always_comb begin
    fault_d = FLT_NONE;
    paddr_d = '0;
    if (seg_u) begin
      paddr_d = req_vaddr_i & UNMAP_MASK;
    end else if (seg_c) begin
      paddr_d = req_vaddr_i & UNMAP_MASK;
      if (!req_kernel_i || mis) fault_d = FLT_ADDR;
    end else if (mis)  fault_d = FLT_ADDR;
    else if (!hit)     fault_d = FLT_REFILL;
    else begin
      fault_d = pg_fault;
      paddr_d = pg_paddr;
    end
  end

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_fault_o <= FLT_NONE;
      rsp_vpn_o   <= '0;
      rsp_vaddr_o <= '0;
      rsp_asid_o  <= '0;
      rsp_write_o <= 1'b0;
    end else if (accept) begin
      rsp_valid_o <= 1'b1;
      rsp_paddr_o <= paddr_d;
      rsp_fault_o <= fault_d;
      rsp_vpn_o   <= vpn;
      rsp_vaddr_o <= req_vaddr_i;
      rsp_asid_o  <= req_asid_i;
      rsp_write_o <= req_write_i;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tlbx_translator_chk.sv
module tlbx_translator_chk
  import tlbx_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              small_pg_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [31:0]       req_vaddr_i,
  input logic [2:0]        req_size_i,
  input logic              req_write_i,
  input logic [7:0]        req_asid_i,
  input logic              req_kernel_i,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [20:0]       wr_vpn2_i,
  input logic [7:0]        wr_asid_i,
  input logic              wr_global_i,
  input logic [1:0]        wr_psel_i,
  input logic [19:0]       wr_pfn0_i,
  input logic              wr_v0_i,
  input logic              wr_d0_i,
  input logic [19:0]       wr_pfn1_i,
  input logic              wr_v1_i,
  input logic              wr_d1_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [31:0]       rsp_paddr_o,
  input logic [2:0]        rsp_fault_o,
  input logic [20:0]       rsp_vpn_o,
  input logic [31:0]       rsp_vaddr_o,
  input logic [7:0]        rsp_asid_o,
  input logic              rsp_write_o
);
  logic acc, mis;
  assign acc = req_valid_i && req_ready_o;
  assign mis = |(req_vaddr_i[2:0] & (req_size_i - 3'd1));

  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o) &&
      $stable(rsp_fault_o) && $stable(rsp_vpn_o) && $stable(rsp_vaddr_o));

  assert_user_cached_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_vaddr_i[31:29] == 3'b100 && !req_kernel_i |=> rsp_fault_o == FLT_ADDR);

  assert_uncached_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_vaddr_i[31:29] == 3'b101 |=>
      rsp_fault_o == FLT_NONE && rsp_paddr_o == {3'b000, $past(req_vaddr_i[28:0])});

  assert_misalign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && mis && req_vaddr_i[31:29] != 3'b101 |=>
      rsp_fault_o == FLT_ADDR && rsp_write_o == $past(req_write_i));

  assert_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_fault_o <= FLT_MODIFIED);
endmodule

bind tlbx_translator tlbx_translator_chk #(.N_ENT(N_ENT)) u_chk (.*);

// File: tb/tb_tlbx_translator.sv
module tb_tlbx_translator;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        small_pg = 0, req_valid = 0, req_write = 0, req_kernel = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = 0;
  logic [2:0]  req_size = 3'd4;
  logic [7:0]  req_asid = 0;
  logic        wr_en = 0, wr_global = 0, wr_v0 = 0, wr_d0 = 0, wr_v1 = 0, wr_d1 = 0;
  logic [2:0]  wr_idx = 0;
  logic [20:0] wr_vpn2 = 0;
  logic [7:0]  wr_asid = 0;
  logic [1:0]  wr_psel = 0;
  logic [19:0] wr_pfn0 = 0, wr_pfn1 = 0;
  logic        rsp_valid, rsp_ready = 1, rsp_write;
  logic [31:0] rsp_paddr, rsp_vaddr;
  logic [2:0]  rsp_fault;
  logic [20:0] rsp_vpn;
  logic [7:0]  rsp_asid;

  tlbx_translator dut (
    .clk_i(clk), .rst_ni(rst_n), .small_pg_i(small_pg),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_size_i(req_size), .req_write_i(req_write), .req_asid_i(req_asid),
    .req_kernel_i(req_kernel), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_vpn2_i(wr_vpn2), .wr_asid_i(wr_asid), .wr_global_i(wr_global),
    .wr_psel_i(wr_psel), .wr_pfn0_i(wr_pfn0), .wr_v0_i(wr_v0), .wr_d0_i(wr_d0),
    .wr_pfn1_i(wr_pfn1), .wr_v1_i(wr_v1), .wr_d1_i(wr_d1),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_paddr_o(rsp_paddr),
    .rsp_fault_o(rsp_fault), .rsp_vpn_o(rsp_vpn), .rsp_vaddr_o(rsp_vaddr),
    .rsp_asid_o(rsp_asid), .rsp_write_o(rsp_write)
  );

  int n_chk = 0, n_bad = 0;
  logic [2:0]  q_f[$];
  logic [31:0] q_pa[$];
  logic [20:0] q_vpn[$];
  logic        q_wr[$];
  logic [7:0]  q_asid[$];
  string       q_tag[$];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ent(input logic [2:0] idx, input logic [20:0] vpn2, input logic [7:0] asid,
                        input logic g, input logic [1:0] ps,
                        input logic [19:0] p0, input logic v0, input logic d0,
                        input logic [19:0] p1, input logic v1, input logic d1);
    @(posedge clk); #1;
    wr_en = 1; wr_idx = idx; wr_vpn2 = vpn2; wr_asid = asid; wr_global = g; wr_psel = ps;
    wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0; wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  // driver: present request, push expectation on acceptance
  task automatic send(string tag, input logic [31:0] va, input logic [2:0] sz, input logic w,
                      input logic [7:0] asid, input logic k,
                      input logic [2:0] ef, input logic [31:0] epa, input logic [20:0] evpn);
    @(posedge clk); #1;
    req_valid = 1; req_vaddr = va; req_size = sz; req_write = w; req_asid = asid; req_kernel = k;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q_f.push_back(ef); q_pa.push_back(epa); q_vpn.push_back(evpn);
    q_wr.push_back(w); q_asid.push_back(asid); q_tag.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (q_f.size() == 0) check("unexpected response", 64'(rsp_fault), 64'hF);
        else begin
          automatic logic [2:0] f = q_f.pop_front();
          automatic logic [31:0] pa = q_pa.pop_front();
          automatic logic [20:0] vp = q_vpn.pop_front();
          automatic logic w = q_wr.pop_front();
          automatic logic [7:0] a = q_asid.pop_front();
          automatic string t = q_tag.pop_front();
          check({t, " fault"}, 64'(rsp_fault), 64'(f));
          check({t, " write"}, 64'(rsp_write), 64'(w));
          if (f == 3'd0) check({t, " paddr"}, 64'(rsp_paddr), 64'(pa));
          if (f >= 3'd2) begin
            check({t, " vpn"}, 64'(rsp_vpn), 64'(vp));
            check({t, " asid"}, 64'(rsp_asid), 64'(a));
          end
        end
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R1 req_ready after reset", 64'(req_ready), 64'd1);

    // R11: cleared entries hit VPN 0 / ASID 0 with invalid halves
    send("R11 cleared entry", 32'h0000_0000, 3'd4, 0, 8'd0, 0, 3'd3, 0, 21'h0);

    wr_ent(3'd0, 21'h000800, 8'd5, 0, 2'd0, 20'h12345, 1, 1, 20'h00ABC, 1, 0);
    wr_ent(3'd1, 21'h002000, 8'd0, 1, 2'd1, 20'h11113, 1, 1, 20'h22220, 0, 0);
    wr_ent(3'd2, 21'h004000, 8'd1, 0, 2'd0, 20'h0AAAA, 1, 1, 20'h0, 0, 0);
    wr_ent(3'd3, 21'h004000, 8'd1, 0, 2'd0, 20'h0BBBB, 1, 1, 20'h0, 0, 0);

    send("R7 R10 even half", 32'h0040_0123, 3'd1, 0, 8'd5, 0, 3'd0, 32'h1234_5123, 0);
    send("R9 write clean odd", 32'h0040_1454, 3'd4, 1, 8'd5, 0, 3'd4, 0, 21'h000800);
    send("R9 read clean odd", 32'h0040_1454, 3'd2, 0, 8'd5, 0, 3'd0, 32'h00AB_C454, 0);
    send("R9 write dirty even", 32'h0040_0010, 3'd4, 1, 8'd5, 0, 3'd0, 32'h1234_5010, 0);
    send("R5 R6 asid mismatch", 32'h0040_0000, 3'd4, 0, 8'd6, 0, 3'd2, 0, 21'h000800);
    send("R4 misaligned mapped", 32'h0040_0002, 3'd4, 1, 8'd5, 0, 3'd1, 0, 0);
    send("R5 R10 global 16K", 32'h0100_2ABC, 3'd4, 0, 8'd9, 0, 3'd0, 32'h1111_2ABC, 0);
    send("R8 odd invalid", 32'h0100_4000, 3'd4, 0, 8'd9, 0, 3'd3, 0, 21'h002008);
    send("R5 mask upper pair", 32'h0100_7FF0, 3'd4, 0, 8'd2, 0, 3'd3, 0, 21'h00200C);
    send("R5 lowest index", 32'h0200_0010, 3'd4, 0, 8'd1, 0, 3'd0, 32'h0AAA_A010, 0);
    send("R6 refill high seg", 32'hC000_0000, 3'd4, 1, 8'd5, 1, 3'd2, 0, 21'h180000);
    send("R6 refill normal vpn", 32'h0300_1800, 3'd4, 0, 8'd1, 0, 3'd2, 0, 21'h006000);
    @(posedge clk); #1 small_pg = 1;
    send("R6 refill small pg", 32'h0300_1800, 3'd4, 0, 8'd1, 0, 3'd2, 0, 21'h006003);
    @(posedge clk); #1 small_pg = 0;
    send("R2 cached kernel", 32'h8012_3454, 3'd4, 0, 8'd0, 1, 3'd0, 32'h0012_3454, 0);
    send("R2 cached user", 32'h8012_3454, 3'd4, 0, 8'd0, 0, 3'd1, 0, 0);
    send("R2 cached misaligned", 32'h8000_0001, 3'd2, 1, 8'd0, 1, 3'd1, 0, 0);
    send("R3 uncached user misaligned", 32'hA000_1233, 3'd4, 0, 8'd0, 0, 3'd0, 32'h0000_1233, 0);

    // R1 backpressure
    @(posedge clk); #1 rsp_ready = 0;
    send("R1 held response", 32'hA000_0040, 3'd4, 0, 8'd0, 0, 3'd0, 32'h0000_0040, 0);
    repeat (3) @(negedge clk);
    check("R1 valid held", 64'(rsp_valid), 64'd1);
    check("R1 ready low", 64'(req_ready), 64'd0);
    check("R1 paddr held", 64'(rsp_paddr), 64'h40);
    @(posedge clk); #1 rsp_ready = 1;

    for (int i = 0; i < 50 && q_f.size() != 0; i++) @(negedge clk);
    check("queue drained", 64'(q_f.size()), 64'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule